// File: doc/BRIEF.md
# Coherence Check Epoch Sequencer

This block is the master-side controller for a cache-coherence debug mode. While the mode is on, time is split into epochs. Each epoch starts with normal running, during which the caches log coherence activity. When some history line fills up, the block runs a checking phase. It stalls the cores and pauses every L1 slave checker, then waits for all of them to acknowledge. It holds until outstanding memory traffic has drained. It then walks the L2 index space, broadcasting each valid line's index and history. Each broadcast waits for a verdict from every slave before the walk moves on. After the walk, it asks each slave to sweep its own lines for valid entries that were never checked. When all slaves report completion, it releases the cores for the next epoch.

Any mismatch stops the sequencer for good. It holds the cores, raises an error flag, and keeps the failing L2 index (or a sweep-failure marker) until reset, so the logged history can be inspected. With the mode off, the block stays inert. Slaves are modelled as plain handshake vectors, one bit per slave.

The states are:
- OFF: mode disabled.
- RUN: normal epoch running.
- PAUSE: pause request out, collecting acknowledgements.
- DRAIN: waiting for in-flight traffic to finish.
- PROBE: examining one L2 index.
- BCAST: broadcast out, collecting verdicts.
- SWEEP: sweep request out, collecting completions; this state also does the synchronisation.
- HALT: fail-stop.

The transitions are:
- OFF→RUN when the mode turns on.
- RUN→OFF when the mode turns off.
- RUN→PAUSE on a history-full request.
- PAUSE→DRAIN when all slaves have acknowledged.
- DRAIN→PROBE when traffic is idle.
- PROBE→BCAST when the line is valid.
- PROBE→PROBE to step to the next index.
- PROBE→SWEEP after the last index.
- BCAST→PROBE or BCAST→SWEEP when all verdicts pass.
- BCAST→HALT on any failing verdict.
- SWEEP→RUN when all slaves are done.
- SWEEP→HALT on any sweep failure.

Top module: `coh_epoch_seq`

## Requirements
- R1: After reset, `phase` is 0 (OFF), and `stall_cores`, `hist_claim`, `pause_req`, `bcast_vld`, `sweep_req` and `err_flag` are all low.
- R2: While `mode_en` is low the block stays in OFF (phase 0), ignores `hist_full`, and keeps `stall_cores`, `hist_claim` and `pause_req` low. Raising `mode_en` moves it to RUN (phase 1) one cycle later, with `hist_claim` high and `stall_cores` low. Dropping `mode_en` in RUN returns it to OFF one cycle later.
- R3: `hist_full` seen in RUN moves the block to PAUSE (phase 2), where `stall_cores` and `pause_req` are high. Acknowledgements are remembered per slave and may arrive in any order. PAUSE is left only once every slave has acknowledged.
- R4: In DRAIN (phase 3) the block holds, with `stall_cores` high and no broadcast, until `drain_idle` is high.
- R5: Starting at index 0, the block visits L2 indices in ascending order (PROBE, phase 4). It broadcasts every line whose `line_valid` is high exactly once (BCAST, phase 5), with `bcast_idx` equal to that index and `bcast_hist` equal to the `line_hist` sampled at that index. Invalid lines are skipped, and the next index is visited only after all slaves have returned a verdict.
- R6: After the last index, the block raises `sweep_req` (SWEEP, phase 6) until every slave has raised `sweep_done`. It then returns to RUN with `stall_cores` low. With no valid line at all, the sweep still runs.
- R7: A slave reporting `res_fail` together with `res_vld` moves the block to HALT (phase 7). There, `err_flag` is high, `err_sweep` is low and `err_idx` holds the index being broadcast. No further line is broadcast.
- R8: A slave reporting `sweep_fail` together with `sweep_done` moves the block to HALT with `err_flag` and `err_sweep` high.
- R9: HALT is left only by reset. `stall_cores` stays high there, and `hist_full` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Coherence debug mode enable |
| hist_full | input | 1 | Some history line reached its entry limit |
| drain_idle | input | 1 | No outstanding memory operation or queued request |
| pause_ack | input | N_SLV | Per-slave pause acknowledgement |
| line_valid | input | 1 | Valid bit of the L2 line at `probe_idx` |
| line_hist | input | HIST_W | Coherence history of the L2 line at `probe_idx` |
| res_vld | input | N_SLV | Per-slave verdict strobe for the current broadcast |
| res_fail | input | N_SLV | Per-slave mismatch flag, read with `res_vld` |
| sweep_done | input | N_SLV | Per-slave sweep completion |
| sweep_fail | input | N_SLV | Per-slave unchecked-valid-line flag, read with `sweep_done` |
| phase | output | 3 | Current state code (0 OFF … 7 HALT) |
| stall_cores | output | 1 | Blocks new memory requests from the cores |
| hist_claim | output | 1 | History storage is reserved for logging |
| pause_req | output | 1 | Pause request to all slaves |
| probe_idx | output | IDX_W | L2 index being examined |
| bcast_vld | output | 1 | Broadcast of one line is active |
| bcast_idx | output | IDX_W | Index of the broadcast line |
| bcast_hist | output | HIST_W | History of the broadcast line |
| sweep_req | output | 1 | Sweep request to all slaves |
| err_flag | output | 1 | A coherence mismatch was found |
| err_sweep | output | 1 | The mismatch came from a sweep |
| err_idx | output | IDX_W | L2 index of the failing broadcast |

## Verification
The bench goes after the pause handshake with one slave held back. A sequencer that counted acknowledgements wrongly, or forgot earlier ones, would drain with a slave still running or would never leave PAUSE. It holds `drain_idle` low to show that no broadcast leaks out before traffic settles. It runs walks over full, sparse, empty and last-line-only valid maps against a scoreboard of expected indices and histories; an off-by-one walker would skip index 0 or the final index, or broadcast an invalid line. Failure cases inject a verdict mismatch mid-walk and a sweep failure. A sequencer that resumed after an error, latched the wrong index, or kept walking would show up as a wrong `err_idx`, a release of the stall, or extra broadcasts.

// File: rtl/coh_seq_pkg.sv
package coh_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_RUN   = 3'd1,
        ST_PAUSE = 3'd2,
        ST_DRAIN = 3'd3,
        ST_PROBE = 3'd4,
        ST_BCAST = 3'd5,
        ST_SWEEP = 3'd6,
        ST_HALT  = 3'd7
    } seq_state_t;
endpackage

// File: rtl/coh_seq_collect.sv
// Sticky per-slave collector: remembers which slaves have answered in the
// current phase and whether any answer carried a failure.
module coh_seq_collect #(
    parameter int N_SLV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N_SLV-1:0] in_vld,
    input  logic [N_SLV-1:0] in_fail,
    output logic             all_seen,
    output logic             any_fail
);
    logic [N_SLV-1:0] seen_q;
    logic [N_SLV-1:0] fail_q;

    for (genvar s = 0; s < N_SLV; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                seen_q[s] <= 1'b0;
                fail_q[s] <= 1'b0;
            end else if (in_vld[s]) begin
                seen_q[s] <= 1'b1;
                fail_q[s] <= fail_q[s] | in_fail[s];
            end
        end
    end

    assign all_seen = &(seen_q | in_vld);
    assign any_fail = |(fail_q | (in_vld & in_fail));
endmodule

// File: rtl/coh_seq_walker.sv
// L2 index walker: restarts at zero on clr, advances by one on step.
module coh_seq_walker #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            idx <= '0;
        else if (step)
            idx <= idx + 1'b1;
    end

    assign last = (idx == IDX_MAX);
endmodule

// File: rtl/coh_epoch_seq.sv
module coh_epoch_seq
    import coh_seq_pkg::*;
#(
    parameter int N_SLV  = 4,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              hist_full,
    input  logic              drain_idle,
    input  logic [N_SLV-1:0]  pause_ack,
    input  logic              line_valid,
    input  logic [HIST_W-1:0] line_hist,
    input  logic [N_SLV-1:0]  res_vld,
    input  logic [N_SLV-1:0]  res_fail,
    input  logic [N_SLV-1:0]  sweep_done,
    input  logic [N_SLV-1:0]  sweep_fail,
    output logic [2:0]        phase,
    output logic              stall_cores,
    output logic              hist_claim,
    output logic              pause_req,
    output logic [IDX_W-1:0]  probe_idx,
    output logic              bcast_vld,
    output logic [IDX_W-1:0]  bcast_idx,
    output logic [HIST_W-1:0] bcast_hist,
    output logic              sweep_req,
    output logic              err_flag,
    output logic              err_sweep,
    output logic [IDX_W-1:0]  err_idx
);
    seq_state_t state, state_nxt;

    logic             col_clr, all_seen, any_fail;
    logic [N_SLV-1:0] col_vld, col_fail;
    logic             walk_clr, walk_step, walk_last;
    logic [IDX_W-1:0] walk_idx;

    // Collector input selection by phase
    always_comb begin
        col_vld  = '0;
        col_fail = '0;
        unique case (state)
            ST_PAUSE: col_vld = pause_ack;
            ST_BCAST: begin col_vld = res_vld;    col_fail = res_fail;   end
            ST_SWEEP: begin col_vld = sweep_done; col_fail = sweep_fail; end
            default: ;
        endcase
    end

    assign col_clr = (state_nxt != state);

    coh_seq_collect #(.N_SLV(N_SLV)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (col_clr),
        .in_vld   (col_vld),
        .in_fail  (col_fail),
        .all_seen (all_seen),
        .any_fail (any_fail)
    );

    assign walk_clr  = (state == ST_DRAIN);
    assign walk_step = ((state == ST_PROBE) && !line_valid && !walk_last) ||
                       ((state == ST_BCAST) && all_seen && !any_fail && !walk_last);

    coh_seq_walker #(.IDX_W(IDX_W)) u_walker (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (walk_clr),
        .step  (walk_step),
        .idx   (walk_idx),
        .last  (walk_last)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (mode_en) state_nxt = ST_RUN;
            ST_RUN:   if (!mode_en) state_nxt = ST_OFF;
                      else if (hist_full) state_nxt = ST_PAUSE;
            ST_PAUSE: if (all_seen) state_nxt = ST_DRAIN;
            ST_DRAIN: if (drain_idle) state_nxt = ST_PROBE;
            ST_PROBE: if (line_valid) state_nxt = ST_BCAST;
                      else if (walk_last) state_nxt = ST_SWEEP;
            ST_BCAST: if (any_fail) state_nxt = ST_HALT;
                      else if (all_seen) state_nxt = walk_last ? ST_SWEEP : ST_PROBE;
            ST_SWEEP: if (any_fail) state_nxt = ST_HALT;
                      else if (all_seen) state_nxt = ST_RUN;
            ST_HALT:  state_nxt = ST_HALT;
            default:  state_nxt = ST_OFF;
        endcase
    end

    // State register and latched data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            bcast_hist <= '0;
            err_flag   <= 1'b0;
            err_sweep  <= 1'b0;
            err_idx    <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_PROBE && line_valid)
                bcast_hist <= line_hist;
            if (state != ST_HALT && state_nxt == ST_HALT) begin
                err_flag <= 1'b1;
                if (state == ST_BCAST)
                    err_idx <= walk_idx;
                else
                    err_sweep <= 1'b1;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        stall_cores = 1'b0;
        hist_claim  = 1'b0;
        pause_req   = 1'b0;
        bcast_vld   = 1'b0;
        sweep_req   = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_RUN:   hist_claim = 1'b1;
            ST_PAUSE: begin hist_claim = 1'b1; stall_cores = 1'b1; pause_req = 1'b1; end
            ST_DRAIN, ST_PROBE, ST_HALT:
                      begin hist_claim = 1'b1; stall_cores = 1'b1; end
            ST_BCAST: begin hist_claim = 1'b1; stall_cores = 1'b1; bcast_vld = 1'b1; end
            ST_SWEEP: begin hist_claim = 1'b1; stall_cores = 1'b1; sweep_req = 1'b1; end
            default:  ;
        endcase
    end

    assign phase     = state;
    assign probe_idx = walk_idx;
    assign bcast_idx = walk_idx;
endmodule

// File: rtl/coh_epoch_seq_chk.sv
module coh_epoch_seq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       phase,
    input logic             stall_cores,
    input logic             hist_claim,
    input logic             pause_req,
    input logic             drain_idle,
    input logic             line_valid,
    input logic [IDX_W-1:0] probe_idx,
    input logic [IDX_W-1:0] bcast_idx,
    input logic             err_flag
);
    // R2: disabled mode stays quiet
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0) |-> (!stall_cores && !hist_claim && !pause_req));

    // R3: drain only entered out of the pause handshake
    a_r3_drain_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |-> ($past(phase) == 3'd2 || $past(phase) == 3'd3));

    // R4: drain holds while traffic is outstanding
    a_r4_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && !drain_idle) |=> (phase == 3'd3));

    // R5: a broadcast begins only for a probed valid line at the same index
    a_r5_bcast_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5 && $past(phase) == 3'd4) |->
            ($past(line_valid) && bcast_idx == $past(probe_idx)));

    // R6: resuming from a sweep never happens with an error latched
    a_r6_clean_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && $past(phase) == 3'd6) |-> !err_flag);

    // R9: halt is permanent and keeps the cores stalled
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd7) |=> (phase == 3'd7 && err_flag && stall_cores));
endmodule

bind coh_epoch_seq coh_epoch_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase),
    .stall_cores (stall_cores),
    .hist_claim  (hist_claim),
    .pause_req   (pause_req),
    .drain_idle  (drain_idle),
    .line_valid  (line_valid),
    .probe_idx   (probe_idx),
    .bcast_idx   (bcast_idx),
    .err_flag    (err_flag)
);

// File: tb/coh_epoch_seq_test.sv
module coh_epoch_seq_test;
    localparam int N_SLV  = 4;
    localparam int IDX_W  = 4;
    localparam int HIST_W = 16;
    localparam int LINES  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, hist_full = 1'b0, drain_idle = 1'b1;
    logic [N_SLV-1:0] pause_ack = '0, res_vld = '0, res_fail = '0;
    logic [N_SLV-1:0] sweep_done = '0, sweep_fail = '0;
    logic line_valid;
    logic [HIST_W-1:0] line_hist;
    logic [2:0] phase;
    logic stall_cores, hist_claim, pause_req, bcast_vld, sweep_req;
    logic err_flag, err_sweep;
    logic [IDX_W-1:0] probe_idx, bcast_idx, err_idx;
    logic [HIST_W-1:0] bcast_hist;

    logic [LINES-1:0] l2v = '0;
    bit hold_p0 = 0, fail_en = 0, sfail_en = 0;
    int fail_line = 0, fail_slave = 0;
    int checks = 0, errors = 0;
    bit finished = 0;
    int unsigned exp_q[$];

    always #4 clk = ~clk;

    function automatic logic [HIST_W-1:0] hist_of(input int i);
        return HIST_W'(16'hA500 ^ (i * 16'h0131));
    endfunction

    assign line_valid = l2v[probe_idx];
    assign line_hist  = hist_of(int'(probe_idx));

    coh_epoch_seq #(.N_SLV(N_SLV), .IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .hist_full(hist_full),
        .drain_idle(drain_idle), .pause_ack(pause_ack), .line_valid(line_valid),
        .line_hist(line_hist), .res_vld(res_vld), .res_fail(res_fail),
        .sweep_done(sweep_done), .sweep_fail(sweep_fail), .phase(phase),
        .stall_cores(stall_cores), .hist_claim(hist_claim), .pause_req(pause_req),
        .probe_idx(probe_idx), .bcast_vld(bcast_vld), .bcast_idx(bcast_idx),
        .bcast_hist(bcast_hist), .sweep_req(sweep_req), .err_flag(err_flag),
        .err_sweep(err_sweep), .err_idx(err_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Slave models: respond at negedge, staggered per slave
    initial begin
        int pc = 0, bc = 0, sc = 0;
        forever begin
            @(negedge clk);
            pc = pause_req ? pc + 1 : 0;
            bc = bcast_vld ? bc + 1 : 0;
            sc = sweep_req ? sc + 1 : 0;
            for (int s = 0; s < N_SLV; s++) begin
                pause_ack[s]  = pause_req && (pc >= N_SLV - s) && !(s == 0 && hold_p0);
                res_vld[s]    = bcast_vld && (bc >= s + 1);
                res_fail[s]   = res_vld[s] && fail_en && (s == fail_slave) &&
                                (int'(bcast_idx) == fail_line);
                sweep_done[s] = sweep_req && (sc >= 2 * s + 1);
                sweep_fail[s] = sweep_done[s] && sfail_en && (s == fail_slave);
            end
        end
    end

    // Scoreboard monitor: one pop per new broadcast
    initial begin
        bit prev_b = 0;
        forever begin
            @(negedge clk);
            if (rst_n && bcast_vld && !prev_b) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected broadcast idx", 32'(bcast_idx), 32'hFFFF);
                end else begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    chk(32'(bcast_idx) == e, "R5", "broadcast idx", 32'(bcast_idx), e);
                    chk(bcast_hist == hist_of(int'(e)), "R5", "broadcast hist",
                        32'(bcast_hist), 32'(hist_of(int'(e))));
                end
            end
            prev_b = bcast_vld;
        end
    end

    task automatic wait_phase(input logic [2:0] want, input string req);
        int n = 0;
        while (phase != want && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(phase == want, req, "phase reached", 32'(phase), 32'(want));
    endtask

    task automatic pulse_full();
        hist_full = 1'b1;
        @(negedge clk);
        hist_full = 1'b0;
        @(negedge clk);
    endtask

    task automatic push_exp(input logic [LINES-1:0] m, input int upto);
        for (int i = 0; i < LINES && i <= upto; i++)
            if (m[i]) exp_q.push_back(i);
    endtask

    task automatic epoch(input logic [LINES-1:0] m);
        l2v = m;
        push_exp(m, LINES - 1);
        pulse_full();
        wait_phase(3'd1, "R6");
        chk(stall_cores == 1'b0, "R6", "stall released", 32'(stall_cores), 0);
        chk(exp_q.size() == 0, "R5", "all valid lines broadcast", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode_en = 1'b0;
        fail_en = 0; sfail_en = 0; hold_p0 = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        bit quiet;
        do_reset();
        // R1 reset state
        chk(phase == 3'd0, "R1", "phase", 32'(phase), 0);
        chk(!stall_cores && !hist_claim && !pause_req && !bcast_vld && !sweep_req && !err_flag,
            "R1", "outputs low", {27'd0, stall_cores, hist_claim, pause_req, bcast_vld, sweep_req}, 0);

        // R2 disabled: hist_full ignored
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            hist_full = (i % 3 == 0);
            @(negedge clk);
            if (phase != 3'd0 || stall_cores || hist_claim || pause_req) quiet = 0;
        end
        hist_full = 1'b0;
        chk(quiet, "R2", "inert while disabled", 32'(phase), 0);

        mode_en = 1'b1;
        @(negedge clk);
        chk(phase == 3'd1 && hist_claim && !stall_cores, "R2", "enter RUN",
            32'(phase), 1);

        // R3 pause waits for the held-back slave
        hold_p0 = 1;
        l2v = 16'h8421;
        push_exp(16'h8421, LINES - 1);
        drain_idle = 1'b0;
        pulse_full();
        repeat (10) @(negedge clk);
        chk(phase == 3'd2 && stall_cores && pause_req, "R3", "held in PAUSE", 32'(phase), 2);
        hold_p0 = 0;
        wait_phase(3'd3, "R3");
        // R4 drain holds
        repeat (8) @(negedge clk);
        chk(phase == 3'd3 && !bcast_vld && stall_cores, "R4", "held in DRAIN", 32'(phase), 3);
        drain_idle = 1'b1;
        wait_phase(3'd1, "R6");
        chk(exp_q.size() == 0, "R5", "sparse map broadcast", exp_q.size(), 0);

        // R5/R6 several valid maps
        epoch({LINES{1'b1}});
        epoch(16'h0001);
        epoch(16'h8000);
        epoch(16'h0000);   // R6 empty map still sweeps

        // R2 dropping the mode
        mode_en = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0 && !hist_claim, "R2", "back to OFF", 32'(phase), 0);

        // R7 mismatch mid-walk, R9 halt sticky
        mode_en = 1'b1;
        @(negedge clk);
        fail_en = 1; fail_line = 5; fail_slave = 2;
        l2v = 16'h0F3A;
        push_exp(16'h0F3A, 5);
        pulse_full();
        wait_phase(3'd7, "R7");
        chk(err_flag && !err_sweep, "R7", "error flags", {30'd0, err_flag, err_sweep}, 2);
        chk(err_idx == 4'd5, "R7", "err_idx", 32'(err_idx), 5);
        hist_full = 1'b1;
        repeat (20) @(negedge clk);
        hist_full = 1'b0;
        chk(phase == 3'd7 && stall_cores, "R9", "halt holds", 32'(phase), 7);
        chk(exp_q.size() == 0, "R7", "no broadcast after fail", exp_q.size(), 0);

        // R8 sweep failure
        do_reset();
        mode_en = 1'b1;
        @(negedge clk);
        sfail_en = 1; fail_slave = 1;
        l2v = 16'h0000;
        pulse_full();
        wait_phase(3'd7, "R8");
        chk(err_flag && err_sweep, "R8", "sweep error flags", {30'd0, err_flag, err_sweep}, 3);
        repeat (10) @(negedge clk);
        chk(phase == 3'd7 && stall_cores, "R9", "sweep halt holds", 32'(phase), 7);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule